// File: doc/BRIEF.md
# Execute-In-Place Flash Read Controller

This block lets a processor fetch 32-bit words straight out of a serial flash as if it were ordinary memory. A read request on the simple request/acknowledge bus is claimed when transparent-fetch mode is on and the top four address bits equal the programmed page number. The block then drives a byte-level SPI shift engine through a full flash read: the configured read command, one to four address bytes, and four data bytes. It assembles the received bytes into a word and acknowledges the bus with that word.

In burst mode the chip select stays asserted after a word is returned. If the next request targets the following word address, only four more data bytes are clocked and no command or address is sent. A non-sequential address, an idle gap longer than a parameterised limit, or clearing the burst or fetch enable releases the chip select. The next access then starts a new command frame. Requests that the block does not claim get no acknowledge and leave the SPI side untouched.

The controller steps through these states: IDLE (chip select released), CMD_GO and CMD_WAIT (issue the command byte and wait for it), ADR_GO and ADR_WAIT (issue each address byte and wait for it), DAT_GO and DAT_WAIT (issue each dummy byte and capture the received byte), ACK (one-cycle acknowledge) and HOLD (burst kept open). The transitions are: IDLE→CMD_GO on a claimed request; CMD_GO→CMD_WAIT; CMD_WAIT→ADR_GO on byte done; ADR_GO→ADR_WAIT; ADR_WAIT→ADR_GO while address bytes remain, else →DAT_GO; DAT_GO→DAT_WAIT; DAT_WAIT→DAT_GO while data bytes remain, else →ACK; ACK→HOLD when burst is enabled, else →IDLE; HOLD→DAT_GO on a claimed sequential request; HOLD→IDLE on any other request, on a gap timeout, or on a disable.

Top module: `xip_fetch_ctrl`

## Requirements
- R1: After reset spi_cs, spi_go and bus_ack are all 0.
- R2: A request is claimed only when cfg_xip_en is 1 and bus_addr[31:28] equals cfg_page. An unclaimed request never raises spi_cs and is never acknowledged.
- R3: Every new frame starts with cfg_read_cmd as its first byte, at frame position 0.
- R4: After the command come cfg_addr_bytes_m1+1 address bytes. These are the low bytes of the bus address, most significant first. With 3 bytes, address 0x30123458 sends 0x12, 0x34, 0x58.
- R5: Four data bytes follow, each sent as 0x00. The received bytes are packed into bus_rdata with the first byte in bits 7:0 and the fourth in bits 31:24.
- R6: bus_ack is high for exactly one cycle, in the cycle right after the cycle in which the last data byte's spi_done was high. bus_rdata holds the assembled word during that cycle.
- R7: With cfg_burst_en at 0, spi_cs is 0 in the cycle after the acknowledge.
- R8: With cfg_burst_en at 1, spi_cs stays at 1 after the acknowledge. A claimed request to the previous address plus 4 is then served by exactly four data bytes that continue the same frame, with no command and no address bytes.
- R9: While a burst is open, a claimed request to a non-sequential address drops spi_cs for at least one cycle. That request is then served by a full new frame.
- R10: While a burst is open, GAP_LIMIT cycles without a request release spi_cs. The next access then uses a full new frame.
- R11: spi_go pulses for one cycle per byte, only while spi_cs is 1, and no new byte starts before the previous byte's spi_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_xip_en | input | 1 | Transparent-fetch mode enable |
| cfg_burst_en | input | 1 | Keep the frame open for sequential words |
| cfg_page | input | 4 | Served value of bus address bits 31:28 |
| cfg_addr_bytes_m1 | input | 2 | Number of address bytes minus one |
| cfg_read_cmd | input | 8 | Flash read command byte |
| bus_req | input | 1 | Read request, held until acknowledged |
| bus_addr | input | 32 | Read byte address |
| bus_ack | output | 1 | One-cycle read acknowledge |
| bus_rdata | output | 32 | Read data word, valid with bus_ack |
| spi_cs | output | 1 | Flash select to the SPI engine, 1 = selected |
| spi_go | output | 1 | Start a one-byte exchange |
| spi_tx | output | 8 | Byte to transmit, valid with spi_go |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Received byte, valid with spi_done |

## Verification
The bench flash model answers each spi_go with spi_done three cycles later. The controller issues the next spi_go in the cycle right after that spi_done, and raises bus_ack in the cycle after the fourth data spi_done. The model checks every transmitted byte against a queue that the read task fills: each entry holds the expected frame position and the expected byte, so a missing, extra or reordered command or address byte is caught when it occurs. All ports are sampled on the falling edge. The released chip select of R7 is checked on the second falling edge after the acknowledge, which is the first full cycle in which the state register has left ACK. The gap release of R10 is checked well past GAP_LIMIT cycles of idle bus.

// File: rtl/xip_pkg.sv
package xip_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD_GO,
        ST_CMD_WAIT,
        ST_ADR_GO,
        ST_ADR_WAIT,
        ST_DAT_GO,
        ST_DAT_WAIT,
        ST_ACK,
        ST_HOLD
    } xip_state_e;
endpackage

// File: rtl/xip_page_match.sv
module xip_page_match #(
    parameter int PAGE_W = 4
) (
    input  logic              enable,
    input  logic [PAGE_W-1:0] addr_top,
    input  logic [PAGE_W-1:0] page,
    output logic              hit
);
    always_comb hit = enable && (addr_top == page);
endmodule

// File: rtl/xip_word_asm.sv
module xip_word_asm #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic [7:0]         rx_byte,
    output logic [8*LANES-1:0] word,
    output logic               last
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (clear)  idx_q <= '0;
        else if (load)   idx_q <= last ? '0 : idx_q + 1'b1;
    end

    always_comb last = (idx_q == IDX_W'(LANES - 1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             word[8*g +: 8] <= 8'h00;
            else if (load && idx_q == IDX_W'(g))    word[8*g +: 8] <= rx_byte;
        end
    end
endmodule

// File: rtl/xip_gap_timer.sv
module xip_gap_timer #(
    parameter int GAP_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(GAP_LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end

    always_comb expired = (cnt_q == CNT_W'(GAP_LIMIT));
endmodule

// File: rtl/xip_fetch_ctrl.sv
module xip_fetch_ctrl
    import xip_pkg::*;
#(
    parameter int GAP_LIMIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_xip_en,
    input  logic        cfg_burst_en,
    input  logic [3:0]  cfg_page,
    input  logic [1:0]  cfg_addr_bytes_m1,
    input  logic [7:0]  cfg_read_cmd,
    input  logic        bus_req,
    input  logic [31:0] bus_addr,
    output logic        bus_ack,
    output logic [31:0] bus_rdata,
    output logic        spi_cs,
    output logic        spi_go,
    output logic [7:0]  spi_tx,
    input  logic        spi_done,
    input  logic [7:0]  spi_rx
);
    localparam int ADDR_W   = 32;
    localparam int PAGE_W   = 4;
    localparam int LANES    = 4;
    localparam int WORD_INC = LANES;

    xip_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        abyte_q;
    logic              hit, seq_hit, asm_last, gap_expired;

    xip_page_match #(.PAGE_W(PAGE_W)) u_match (
        .enable   (cfg_xip_en),
        .addr_top (bus_addr[ADDR_W-1 -: PAGE_W]),
        .page     (cfg_page),
        .hit      (hit)
    );

    xip_word_asm #(.LANES(LANES)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_IDLE),
        .load    (state_q == ST_DAT_WAIT && spi_done),
        .rx_byte (spi_rx),
        .word    (bus_rdata),
        .last    (asm_last)
    );

    xip_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_HOLD && !bus_req),
        .expired (gap_expired)
    );

    always_comb seq_hit = hit && (bus_addr == addr_q + ADDR_W'(WORD_INC));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (bus_req && hit) state_d = ST_CMD_GO;
            ST_CMD_GO:   state_d = ST_CMD_WAIT;
            ST_CMD_WAIT: if (spi_done) state_d = ST_ADR_GO;
            ST_ADR_GO:   state_d = ST_ADR_WAIT;
            ST_ADR_WAIT: if (spi_done) state_d = (abyte_q == 2'd0) ? ST_DAT_GO : ST_ADR_GO;
            ST_DAT_GO:   state_d = ST_DAT_WAIT;
            ST_DAT_WAIT: if (spi_done) state_d = asm_last ? ST_ACK : ST_DAT_GO;
            ST_ACK:      state_d = cfg_burst_en ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (!cfg_xip_en || !cfg_burst_en || gap_expired) state_d = ST_IDLE;
                else if (bus_req) state_d = seq_hit ? ST_DAT_GO : ST_IDLE;
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            abyte_q <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE && bus_req && hit) ||
                (state_q == ST_HOLD && state_d == ST_DAT_GO))
                addr_q <= bus_addr;
            if (state_q == ST_CMD_WAIT && spi_done)
                abyte_q <= cfg_addr_bytes_m1;
            else if (state_q == ST_ADR_WAIT && spi_done && abyte_q != 2'd0)
                abyte_q <= abyte_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        spi_go  = 1'b0;
        spi_tx  = 8'h00;
        bus_ack = 1'b0;
        spi_cs  = (state_q != ST_IDLE);
        unique case (state_q)
            ST_CMD_GO: begin spi_go = 1'b1; spi_tx = cfg_read_cmd; end
            ST_ADR_GO: begin spi_go = 1'b1; spi_tx = addr_q[{abyte_q, 3'b000} +: 8]; end
            ST_DAT_GO: begin spi_go = 1'b1; spi_tx = 8'h00; end
            ST_ACK:    bus_ack = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/xip_fetch_ctrl_chk.sv
module xip_fetch_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_xip_en,
    input logic        cfg_burst_en,
    input logic [3:0]  cfg_page,
    input logic        bus_req,
    input logic [31:0] bus_addr,
    input logic        bus_ack,
    input logic        spi_cs,
    input logic        spi_go,
    input logic        spi_done
);
    // R11
    go_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |-> spi_cs);
    // R11
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |=> !spi_go);
    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    // R6
    ack_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(spi_done));
    // R2
    cs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs) |-> $past(cfg_xip_en && bus_req && bus_addr[31:28] == cfg_page));
    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !cfg_burst_en) |=> !spi_cs);
endmodule

bind xip_fetch_ctrl xip_fetch_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_xip_en   (cfg_xip_en),
    .cfg_burst_en (cfg_burst_en),
    .cfg_page     (cfg_page),
    .bus_req      (bus_req),
    .bus_addr     (bus_addr),
    .bus_ack      (bus_ack),
    .spi_cs       (spi_cs),
    .spi_go       (spi_go),
    .spi_done     (spi_done)
);

// File: tb/tb_xip_fetch_ctrl.sv
module tb_xip_fetch_ctrl;
    localparam int LAT = 3;
    localparam int GAP = 16;

    logic        clk = 0, rst_n = 0;
    logic        cfg_xip_en = 0, cfg_burst_en = 0;
    logic [3:0]  cfg_page = 4'h3;
    logic [1:0]  cfg_addr_bytes_m1 = 2'd2;
    logic [7:0]  cfg_read_cmd = 8'h0B;
    logic        bus_req = 0;
    logic [31:0] bus_addr = '0;
    logic        bus_ack, spi_cs, spi_go;
    logic [31:0] bus_rdata;
    logic [7:0]  spi_tx;
    logic        spi_done = 0;
    logic [7:0]  spi_rx = 0;

    int vectors = 0, miscompares = 0;
    logic [15:0] exp_tx[$];
    logic [31:0] exp_word[$];
    bit done_flag = 0;

    always #10 clk = ~clk;

    xip_fetch_ctrl #(.GAP_LIMIT(GAP)) dut (.*);

    function automatic logic [7:0] fb(int p);
        return 8'(p * 29 + 7);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // flash model and transmit monitor
    initial begin
        int pos = 0, pend = 0, dly = 0;
        forever begin
            @(negedge clk);
            spi_done = 0;
            if (!spi_cs) pos = 0;
            if (dly != 0) begin
                dly--;
                if (dly == 0) begin spi_done = 1; spi_rx = fb(pend); end
            end
            if (spi_go) begin
                logic [15:0] e;
                if (exp_tx.size() == 0) check(0, "R11 unexpected byte", {16'(pos), 8'h0, spi_tx}, 0);
                else begin
                    e = exp_tx.pop_front();
                    check({8'(pos), spi_tx} == e, "R3/R4/R5/R8/R9 frame byte {pos,byte}",
                          {16'h0, 8'(pos), spi_tx}, {16'h0, e});
                end
                pend = pos; pos++; dly = LAT;
            end
        end
    end

    // read-data monitor
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                if (exp_word.size() == 0) check(0, "R2 unexpected ack", bus_rdata, 0);
                else begin
                    logic [31:0] w;
                    w = exp_word.pop_front();
                    check(bus_rdata == w, "R5/R6 read word", bus_rdata, w);
                end
            end
        end
    end

    // driver: queue the expected frame, then run the bus handshake
    task automatic rd(logic [31:0] a, bit cont, int base);
        int nab, dpos;
        bit got;
        nab = int'(cfg_addr_bytes_m1) + 1;
        if (!cont) begin
            exp_tx.push_back({8'd0, cfg_read_cmd});
            for (int i = 0; i < nab; i++)
                exp_tx.push_back({8'(1 + i), a[8*(nab-1-i) +: 8]});
            dpos = 1 + nab;
        end else dpos = base;
        for (int i = 0; i < 4; i++) exp_tx.push_back({8'(dpos + i), 8'h00});
        exp_word.push_back({fb(dpos+3), fb(dpos+2), fb(dpos+1), fb(dpos)});
        @(negedge clk);
        bus_req = 1; bus_addr = a;
        got = 0;
        for (int t = 0; t < 400 && !got; t++) begin
            @(negedge clk);
            if (bus_ack) got = 1;
        end
        bus_req = 0;
        check(got, "R6 ack arrives", {31'h0, got}, 1);
    endtask

    task automatic no_claim(logic [31:0] a, string req);
        bit seen;
        seen = 0;
        @(negedge clk);
        bus_req = 1; bus_addr = a;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (bus_ack || spi_cs) seen = 1;
        end
        bus_req = 0;
        check(!seen, req, {31'h0, seen}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(!spi_cs && !spi_go && !bus_ack, "R1 reset outputs", {29'h0, spi_cs, spi_go, bus_ack}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!spi_cs && !bus_ack, "R1 idle after reset", {30'h0, spi_cs, bus_ack}, 0);

        // R2: fetch mode off
        no_claim(32'h3000_0040, "R2 disabled mode not claimed");
        cfg_xip_en = 1;
        // R2: outside the page
        no_claim(32'h5000_0040, "R2 out of page not claimed");

        // R3 R4 R5 R6 with three address bytes
        rd(32'h3012_3458, 0, 0);
        @(negedge clk);
        // R7
        check(!spi_cs, "R7 cs released after ack", {31'h0, spi_cs}, 0);
        cfg_addr_bytes_m1 = 2'd0; cfg_read_cmd = 8'h03;
        rd(32'h3000_00AC, 0, 0);     // R4 one address byte
        cfg_addr_bytes_m1 = 2'd3; cfg_read_cmd = 8'hEB;
        rd(32'h3ABC_DEF0, 0, 0);     // R4 four address bytes
        cfg_page = 4'hA;
        rd(32'hA001_0203, 0, 0);     // R2 other page
        cfg_page = 4'h3;

        // R8 burst continuation
        cfg_addr_bytes_m1 = 2'd2; cfg_read_cmd = 8'h0B; cfg_burst_en = 1;
        rd(32'h3000_0100, 0, 0);
        @(negedge clk);
        check(spi_cs, "R8 cs held in burst", {31'h0, spi_cs}, 1);
        rd(32'h3000_0104, 1, 8);
        rd(32'h3000_0108, 1, 12);
        // R9 non-sequential restarts the frame
        rd(32'h3000_0200, 0, 0);
        // R10 idle gap releases the frame
        repeat (GAP + 10) @(negedge clk);
        check(!spi_cs, "R10 cs released after gap", {31'h0, spi_cs}, 0);
        rd(32'h3000_0204, 0, 0);
        cfg_burst_en = 0;
        repeat (3) @(negedge clk);
        check(!spi_cs, "R8 cs released when burst disabled", {31'h0, spi_cs}, 0);

        repeat (10) @(negedge clk);
        // R11 every queued byte was issued
        check(exp_tx.size() == 0 && exp_word.size() == 0, "R11 all bytes and words seen",
              exp_tx.size(), 0);
        done_flag = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done_flag; c++) @(negedge clk);
        if (!done_flag) check(0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule